// File: doc/BRIEF.md
# Group interrupt redistribution unit

When a thread context is descheduled while it still holds an interrupt that was raised for a group or a crowd of virtual processors, and that interrupt has not been acknowledged, some other eligible context has to take it. This block does that hand-back. It samples the ring's notification status, pending priority and current priority registers. It also samples the virtual-processor block and index of the context being pulled. From these it rebuilds the address of the group (or crowd) descriptor and reads that descriptor's second word over a read port.

From the fetched word it takes the target event-queue block and base index. It adds an offset that depends on the pending priority, then sends one notify request to the queue logic. That request carries zero event data and a redistribution flag, so the queue logic posts the event without enqueuing data. Once the notify is accepted, the block writes back the context state: status cleared, pending priority reset to the current priority, and the interrupt line to the thread dropped.

A pull whose status holds no group exception completes at once, with no read and no notify. A descriptor read that fails ends the operation with an error pulse and leaves the context untouched.

Top module: `grp_redist`

## Requirements
- R1: A pull is redistributed only when status bits [7:6] equal 2'b10. Any other value completes the pull with a `done` pulse in the cycle after acceptance, with no read and no notify.
- R2: With group level g = status[3:0] > 0, the descriptor index is the virtual-processor index with its low g bits cleared, ORed with 2^(g-1) − 1. With g = 0 the index passes unchanged.
- R3: With crowd level c = status[5:4] > 0, the descriptor block is formed from the virtual-processor block by the same clear-and-fill rule, and c = 3 is applied as 4. With c = 0 the block passes unchanged.
- R4: `rd_crowd` is 1 when c > 0 (crowd table) and 0 otherwise (group table).
- R5: Descriptor word 1 is numbered MSB-first as 32 bits. Bits 0–1 (`[31:30]`) hold the priority-size code, bits 4–7 (`[27:24]`) the queue block, and bits 8–31 (`[23:0]`) the queue base index.
- R6: The number of priorities is 2^code when configuration bit 7 is 1. Otherwise it is 2^cfg[2:0].
- R7: The notified queue index is the base index plus (pending priority mod number of priorities), wrapping at 24 bits.
- R8: The notify request carries event data 0 and `ntf_redist` = 1.
- R9: In the cycle after the notify handshake, `ctx_wr_valid` pulses for one cycle with `ctx_wr_pipr` equal to the current priority captured at the pull. This pulse means status is cleared and the thread's interrupt line drops. `done` follows one cycle later.
- R10: A read response with `rsp_err` = 1 raises `fetch_err` and `done` in the next cycle, and produces no notify and no context write.
- R11: `pull_ready` is 1 only while idle. A read or notify request that is waiting for its ready holds its valid and its fields stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pull_valid | input | 1 | Context pull request |
| pull_ready | output | 1 | Block is idle and accepts a pull |
| ctx_nsr | input | 8 | Ring notification status |
| ctx_pipr | input | 8 | Ring pending priority |
| ctx_cppr | input | 8 | Ring current priority |
| vp_blk | input | 4 | Virtual-processor block of the pulled context |
| vp_idx | input | 16 | Virtual-processor index of the pulled context |
| cfg | input | 8 | Configuration: bit 7 group-priority enable, [2:0] priority field |
| rd_valid | output | 1 | Descriptor read request |
| rd_ready | input | 1 | Read request accepted |
| rd_crowd | output | 1 | 1 selects crowd table, 0 group table |
| rd_blk | output | 4 | Descriptor block |
| rd_idx | output | 16 | Descriptor index |
| rsp_valid | input | 1 | Read response |
| rsp_err | input | 1 | Read failed |
| rsp_word1 | input | 32 | Descriptor word 1 |
| ntf_valid | output | 1 | Notify request |
| ntf_ready | input | 1 | Notify accepted |
| ntf_qblk | output | 4 | Target queue block |
| ntf_qidx | output | 24 | Target queue index |
| ntf_data | output | 32 | Event data (always 0 here) |
| ntf_redist | output | 1 | Redistribution flag |
| ctx_wr_valid | output | 1 | Clear context: status 0, PIPR load, line drop |
| ctx_wr_pipr | output | 8 | New pending priority |
| fetch_err | output | 1 | Descriptor read error pulse |
| done | output | 1 | Pull handling complete |

## Verification
The assertions check the protocol rules on every cycle. Pull acceptance is blocked while a request is in flight. Read and notify requests hold steady under back-pressure. A context write happens only right after an accepted notify. An error response never produces a notify or a write. The address arithmetic can only be shown by the bench's scenarios: the clear-and-fill of index and block, the crowd code 3 case, the choice of priority count and the 24-bit wrap of the queue index. The bench compares each request against values its own model computes.

// File: rtl/grp_redist_pkg.sv
// Shared types for the group redistribution unit.
// Assumes a 32-bit descriptor word 1 with fixed field positions.
package grp_redist_pkg;
    localparam int W1_W   = 32;
    localparam int QBLK_W = 4;
    localparam int QIDX_W = 24;
    localparam int PSZ_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_NOTIFY,
        ST_CLEAR
    } rd_state_t;
endpackage

// File: rtl/grp_redist_maskfill.sv
// Clears the low LVL bits of a value and fills the low LVL-1 bits with ones.
// Assumes LVL never exceeds W; a level of zero passes the value through.
module grp_redist_maskfill #(
    parameter int W     = 16,
    parameter int LVL_W = 4
) (
    input  logic [W-1:0]     val,
    input  logic [LVL_W-1:0] lvl,
    output logic [W-1:0]     res
);
    logic [W-1:0] keep_mask;
    logic [W-1:0] fill_bits;

    // Builds the mask and fill pattern for the requested level.
    always_comb begin
        keep_mask = {W{1'b1}} << lvl;
        fill_bits = '0;
        if (lvl != '0) begin
            fill_bits = (W'(1) << (lvl - LVL_W'(1))) - W'(1);
        end
        res = (lvl == '0) ? val : ((val & keep_mask) | fill_bits);
    end
endmodule

// File: rtl/grp_redist_addr.sv
// Derives the descriptor table select, block and index from the pulled
// context's block/index and the group and crowd levels of its status.
// Assumes the top crowd code stands for one level higher than its value.
module grp_redist_addr #(
    parameter int BLK_W = 4,
    parameter int IDX_W = 16,
    parameter int GRP_W = 4,
    parameter int CRW_W = 2
) (
    input  logic [BLK_W-1:0] vp_blk,
    input  logic [IDX_W-1:0] vp_idx,
    input  logic [GRP_W-1:0] grp_lvl,
    input  logic [CRW_W-1:0] crw_lvl,
    output logic             crowd_sel,
    output logic [BLK_W-1:0] desc_blk,
    output logic [IDX_W-1:0] desc_idx
);
    localparam int CEFF_W = CRW_W + 1;
    logic [CEFF_W-1:0] crw_eff;

    // Maps the topmost crowd code one step up; others pass through.
    always_comb begin
        crw_eff   = (crw_lvl == {CRW_W{1'b1}}) ? ({1'b0, crw_lvl} + CEFF_W'(1))
                                              : {1'b0, crw_lvl};
        crowd_sel = (crw_lvl != '0);
    end

    grp_redist_maskfill #(.W(IDX_W), .LVL_W(GRP_W)) u_idx_mf (
        .val (vp_idx),
        .lvl (grp_lvl),
        .res (desc_idx)
    );

    grp_redist_maskfill #(.W(BLK_W), .LVL_W(CEFF_W)) u_blk_mf (
        .val (vp_blk),
        .lvl (crw_eff),
        .res (desc_blk)
    );
endmodule

// File: rtl/grp_redist_target.sv
// Decodes descriptor word 1 and forms the target queue block and index,
// adding the pending priority modulo the active priority count.
// Assumes the priority count is a power of two, so the modulo is a mask.
module grp_redist_target
    import grp_redist_pkg::*;
#(
    parameter int PRIO_W   = 8,
    parameter int CFG_W    = 8,
    parameter int GPE_BIT  = 7,
    parameter int PF_LSB   = 0,
    parameter int PF_W     = 3
) (
    input  logic [W1_W-1:0]   word1,
    input  logic [PRIO_W-1:0] pipr,
    input  logic [CFG_W-1:0]  cfg,
    output logic [QBLK_W-1:0] qblk,
    output logic [QIDX_W-1:0] qidx
);
    localparam int SH_W = (PF_W > PSZ_W) ? PF_W : PSZ_W;

    logic [PSZ_W-1:0]  psize;
    logic [QIDX_W-1:0] base_idx;
    logic [SH_W-1:0]   prio_log2;
    logic [PRIO_W-1:0] prio_off;

    // Extracts fields (MSB-0 bits 0-1, 4-7, 8-31) and adds the offset.
    always_comb begin
        psize     = word1[W1_W-1 -: PSZ_W];
        qblk      = word1[W1_W-5 -: QBLK_W];
        base_idx  = word1[QIDX_W-1:0];
        prio_log2 = cfg[GPE_BIT] ? SH_W'(psize) : SH_W'(cfg[PF_LSB +: PF_W]);
        prio_off  = pipr & ~({PRIO_W{1'b1}} << prio_log2);
        qidx      = base_idx + QIDX_W'(prio_off);
    end
endmodule

// File: rtl/grp_redist.sv
// Top of the group redistribution unit. On an accepted pull it checks the
// status for a group exception, fetches the descriptor, issues one
// redistribution notify and then clears the context state.
// Assumes the requester holds no further pull until pull_ready returns.
module grp_redist
    import grp_redist_pkg::*;
#(
    parameter int BLK_W    = 4,
    parameter int IDX_W    = 16,
    parameter int NSR_W    = 8,
    parameter int PRIO_W   = 8,
    parameter int CFG_W    = 8,
    parameter int DATA_W   = 32,
    parameter int GRP_LSB  = 0,
    parameter int GRP_W    = 4,
    parameter int CRW_LSB  = 4,
    parameter int CRW_W    = 2,
    parameter int OP_LSB   = 6,
    parameter int OP_W     = 2,
    parameter int OP_GROUP = 2,
    parameter int GPE_BIT  = 7,
    parameter int PF_LSB   = 0,
    parameter int PF_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pull_valid,
    output logic              pull_ready,
    input  logic [NSR_W-1:0]  ctx_nsr,
    input  logic [PRIO_W-1:0] ctx_pipr,
    input  logic [PRIO_W-1:0] ctx_cppr,
    input  logic [BLK_W-1:0]  vp_blk,
    input  logic [IDX_W-1:0]  vp_idx,
    input  logic [CFG_W-1:0]  cfg,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic              rd_crowd,
    output logic [BLK_W-1:0]  rd_blk,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic [W1_W-1:0]   rsp_word1,
    output logic              ntf_valid,
    input  logic              ntf_ready,
    output logic [QBLK_W-1:0] ntf_qblk,
    output logic [QIDX_W-1:0] ntf_qidx,
    output logic [DATA_W-1:0] ntf_data,
    output logic              ntf_redist,
    output logic              ctx_wr_valid,
    output logic [PRIO_W-1:0] ctx_wr_pipr,
    output logic              fetch_err,
    output logic              done
);
    rd_state_t         state_q;
    logic [NSR_W-1:0]  nsr_q;
    logic [PRIO_W-1:0] pipr_q;
    logic [PRIO_W-1:0] cppr_q;
    logic [BLK_W-1:0]  blk_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CFG_W-1:0]  cfg_q;
    logic [W1_W-1:0]   word1_q;
    logic              is_group_exc;

    // Group exception test on the live status operation field.
    always_comb begin
        is_group_exc = (ctx_nsr[OP_LSB +: OP_W] == OP_W'(OP_GROUP));
    end

    grp_redist_addr #(
        .BLK_W (BLK_W),
        .IDX_W (IDX_W),
        .GRP_W (GRP_W),
        .CRW_W (CRW_W)
    ) u_addr (
        .vp_blk    (blk_q),
        .vp_idx    (idx_q),
        .grp_lvl   (nsr_q[GRP_LSB +: GRP_W]),
        .crw_lvl   (nsr_q[CRW_LSB +: CRW_W]),
        .crowd_sel (rd_crowd),
        .desc_blk  (rd_blk),
        .desc_idx  (rd_idx)
    );

    grp_redist_target #(
        .PRIO_W  (PRIO_W),
        .CFG_W   (CFG_W),
        .GPE_BIT (GPE_BIT),
        .PF_LSB  (PF_LSB),
        .PF_W    (PF_W)
    ) u_target (
        .word1 (word1_q),
        .pipr  (pipr_q),
        .cfg   (cfg_q),
        .qblk  (ntf_qblk),
        .qidx  (ntf_qidx)
    );

    // Handshake and write-back outputs decoded from the state.
    always_comb begin
        pull_ready   = (state_q == ST_IDLE);
        rd_valid     = (state_q == ST_FETCH);
        ntf_valid    = (state_q == ST_NOTIFY);
        ntf_data     = '0;
        ntf_redist   = 1'b1;
        ctx_wr_valid = (state_q == ST_CLEAR);
        ctx_wr_pipr  = cppr_q;
    end

    // Sequencer: capture on pull, fetch, notify, clear, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            nsr_q     <= '0;
            pipr_q    <= '0;
            cppr_q    <= '0;
            blk_q     <= '0;
            idx_q     <= '0;
            cfg_q     <= '0;
            word1_q   <= '0;
            fetch_err <= 1'b0;
            done      <= 1'b0;
        end else begin
            fetch_err <= 1'b0;
            done      <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (pull_valid) begin
                        nsr_q  <= ctx_nsr;
                        pipr_q <= ctx_pipr;
                        cppr_q <= ctx_cppr;
                        blk_q  <= vp_blk;
                        idx_q  <= vp_idx;
                        cfg_q  <= cfg;
                        if (is_group_exc) begin
                            state_q <= ST_FETCH;
                        end else begin
                            done <= 1'b1;
                        end
                    end
                end
                ST_FETCH: begin
                    if (rd_ready) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rsp_valid) begin
                        if (rsp_err) begin
                            fetch_err <= 1'b1;
                            done      <= 1'b1;
                            state_q   <= ST_IDLE;
                        end else begin
                            word1_q <= rsp_word1;
                            state_q <= ST_NOTIFY;
                        end
                    end
                end
                ST_NOTIFY: begin
                    if (ntf_ready) begin
                        state_q <= ST_CLEAR;
                    end
                end
                ST_CLEAR: begin
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/grp_redist_chk.sv
// Protocol checker for grp_redist, attached by bind below.
module grp_redist_chk #(
    parameter int BLK_W  = 4,
    parameter int IDX_W  = 16,
    parameter int QIDX_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pull_ready,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic              rd_crowd,
    input logic [BLK_W-1:0]  rd_blk,
    input logic [IDX_W-1:0]  rd_idx,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              ntf_valid,
    input logic              ntf_ready,
    input logic [QIDX_W-1:0] ntf_qidx,
    input logic              ctx_wr_valid,
    input logic              fetch_err
);
    AST_BUSY_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || ntf_valid || ctx_wr_valid) |-> !pull_ready); // R11
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_blk) && $stable(rd_idx) && $stable(rd_crowd))); // R11
    AST_NTF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ntf_valid && !ntf_ready) |=> (ntf_valid && $stable(ntf_qidx))); // R11
    AST_WR_AFTER_NTF: assert property (@(posedge clk) disable iff (!rst_n)
        (ntf_valid && ntf_ready) |=> ctx_wr_valid); // R9
    AST_WR_NEEDS_NTF: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_wr_valid |-> $past(ntf_valid && ntf_ready)); // R9
    AST_ERR_FROM_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_err |-> $past(rsp_valid && rsp_err)); // R10
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_err |-> (!ntf_valid && !ctx_wr_valid)); // R10
endmodule

bind grp_redist grp_redist_chk #(
    .BLK_W  (BLK_W),
    .IDX_W  (IDX_W),
    .QIDX_W (grp_redist_pkg::QIDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pull_ready   (pull_ready),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .rd_crowd     (rd_crowd),
    .rd_blk       (rd_blk),
    .rd_idx       (rd_idx),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .ntf_valid    (ntf_valid),
    .ntf_ready    (ntf_ready),
    .ntf_qidx     (ntf_qidx),
    .ctx_wr_valid (ctx_wr_valid),
    .fetch_err    (fetch_err)
);

// File: tb/grp_redist_tb_top.sv
// Bench for grp_redist: directed corner cases then seeded random pulls,
// each checked against a reference model written from the requirements.
module grp_redist_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pull_valid = 1'b0;
    logic        pull_ready;
    logic [7:0]  ctx_nsr = '0;
    logic [7:0]  ctx_pipr = '0;
    logic [7:0]  ctx_cppr = '0;
    logic [3:0]  vp_blk = '0;
    logic [15:0] vp_idx = '0;
    logic [7:0]  cfg = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic        rd_crowd;
    logic [3:0]  rd_blk;
    logic [15:0] rd_idx;
    logic        rsp_valid = 1'b0;
    logic        rsp_err = 1'b0;
    logic [31:0] rsp_word1 = '0;
    logic        ntf_valid;
    logic        ntf_ready = 1'b0;
    logic [3:0]  ntf_qblk;
    logic [23:0] ntf_qidx;
    logic [31:0] ntf_data;
    logic        ntf_redist;
    logic        ctx_wr_valid;
    logic [7:0]  ctx_wr_pipr;
    logic        fetch_err;
    logic        done;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    grp_redist dut_i (.*);

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int mfill(input int v, input int lvl, input int w);
        int r;
        if (lvl == 0) r = v;
        else r = (v & ~((1 << lvl) - 1)) | ((1 << (lvl - 1)) - 1);
        return r & ((1 << w) - 1);
    endfunction

    function automatic int exp_qidx(input int w1, input int pipr, input int c);
        int lg;
        lg = c[7] ? ((w1 >> 30) & 3) : (c & 7);
        return ((w1 & 32'hFFFFFF) + (pipr % (1 << lg))) & 32'hFFFFFF;
    endfunction

    task automatic do_pull(input logic [7:0] nsr, input logic [7:0] pipr,
                           input logic [7:0] cppr, input logic [3:0] blk,
                           input logic [15:0] idx, input logic [7:0] c,
                           input logic [31:0] w1, input bit err,
                           input int rd_dly, input int nt_dly);
        int g, cr, eb, ei, eq;
        @(negedge clk);
        ctx_nsr = nsr; ctx_pipr = pipr; ctx_cppr = cppr;
        vp_blk = blk; vp_idx = idx; cfg = c; pull_valid = 1'b1;
        @(negedge clk);
        pull_valid = 1'b0;
        ctx_nsr = ~nsr; ctx_pipr = ~pipr; ctx_cppr = ~cppr; vp_blk = ~blk; vp_idx = ~idx; cfg = ~c;
        if (nsr[7:6] != 2'b10) begin
            chk(done == 1'b1, "R1 done", done, 1);
            chk(!rd_valid && !ntf_valid, "R1 no request", {rd_valid, ntf_valid}, 0);
            return;
        end
        g = nsr[3:0];
        cr = nsr[5:4];
        ei = mfill(idx, g, 16);
        eb = mfill(blk, (cr == 3) ? 4 : cr, 4);
        chk(rd_valid && !pull_ready, "R11 busy", {rd_valid, pull_ready}, 2);
        chk(rd_idx == 16'(ei), "R2 index", rd_idx, ei);
        chk(rd_blk == 4'(eb), "R3 block", rd_blk, eb);
        chk(rd_crowd == (cr != 0), "R4 table", rd_crowd, cr != 0);
        for (int k = 0; k < rd_dly; k++) @(negedge clk);
        chk(rd_valid && rd_idx == 16'(ei), "R11 read hold", rd_idx, ei);
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0; rsp_valid = 1'b1; rsp_err = err; rsp_word1 = w1;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0; rsp_word1 = ~w1;
        if (err) begin
            chk(fetch_err && done && !ntf_valid && !ctx_wr_valid, "R10 error",
                {fetch_err, done, ntf_valid, ctx_wr_valid}, 4'b1100);
            @(negedge clk);
            chk(!ntf_valid && !ctx_wr_valid && pull_ready, "R10 quiet",
                {ntf_valid, ctx_wr_valid, pull_ready}, 3'b001);
            return;
        end
        eq = exp_qidx(w1, pipr, c);
        chk(ntf_valid, "R8 notify valid", ntf_valid, 1);
        chk(ntf_qblk == w1[27:24], "R5 queue block", ntf_qblk, w1[27:24]);
        chk(ntf_qidx == 24'(eq), "R7 queue index R6", ntf_qidx, eq);
        chk(ntf_data == 0 && ntf_redist, "R8 data/flag", {ntf_redist, ntf_data}, 33'h100000000);
        for (int k = 0; k < nt_dly; k++) @(negedge clk);
        chk(ntf_valid && ntf_qidx == 24'(eq), "R11 notify hold", ntf_qidx, eq);
        ntf_ready = 1'b1;
        @(negedge clk);
        ntf_ready = 1'b0;
        chk(ctx_wr_valid && !ntf_valid, "R9 clear pulse", {ctx_wr_valid, ntf_valid}, 2);
        chk(ctx_wr_pipr == cppr, "R9 pipr load", ctx_wr_pipr, cppr);
        @(negedge clk);
        chk(done && !ctx_wr_valid && pull_ready, "R9 done", {done, ctx_wr_valid, pull_ready}, 5);
    endtask

    initial begin
        int seed;
        seed = 32'h5eed1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pull_ready && !rd_valid && !ntf_valid && !ctx_wr_valid && !done && !fetch_err,
            "R11 reset state", {pull_ready, rd_valid, ntf_valid, done}, 8);
        // R1: non-group status codes
        do_pull(8'h4F, 8'h05, 8'h01, 4'h3, 16'h1234, 8'h82, 32'h0, 1'b0, 0, 0);
        do_pull(8'h00, 8'h05, 8'h01, 4'h3, 16'h1234, 8'h82, 32'h0, 1'b0, 0, 0);
        // R2 g=0, R3 c=0, R6 field path
        do_pull(8'h80, 8'h0D, 8'h02, 4'h9, 16'hABCD, 8'h03, 32'hC5000010, 1'b0, 0, 0);
        // g=1, c=1
        do_pull(8'h91, 8'h07, 8'h03, 4'hE, 16'hFFFF, 8'h81, 32'h4A000100, 1'b0, 2, 1);
        // g=15, crowd code 3 acts as 4 (R3), psize 3 (R6)
        do_pull(8'hBF, 8'hFF, 8'h04, 4'h7, 16'h8001, 8'h80, 32'hC1123456, 1'b0, 1, 3);
        // R7 wrap at 24 bits
        do_pull(8'hA4, 8'h07, 8'h05, 4'h2, 16'h0F0F, 8'h87, 32'hCFFFFFFF, 1'b0, 0, 0);
        // R10 descriptor fetch error
        do_pull(8'h92, 8'h03, 8'h01, 4'h1, 16'h0055, 8'h00, 32'h12345678, 1'b1, 0, 0);
        // seeded random mix
        for (int n = 0; n < 300; n++) begin
            logic [7:0] nsr;
            nsr = 8'($urandom);
            if ($urandom % 4 != 0) nsr[7:6] = 2'b10;
            do_pull(nsr, 8'($urandom), 8'($urandom), 4'($urandom), 16'($urandom),
                    8'($urandom), $urandom, ($urandom % 8) == 0,
                    int'($urandom % 3), int'($urandom % 3));
        end
        repeat (2) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule